// File: doc/BRIEF.md
# Descriptor Ring Producer Credit Manager

This block owns the producer side of one descriptor ring whose size is set by a parameter. Upstream logic asks to post descriptors one at a time. The block advances a producer index, announces every new index, and watches consumer index updates so that the ring never overruns. The top slot of the ring is kept back for a status entry. Producer indices therefore cycle through the lower slots only. One further slot is always left empty, so that a producer index equal to the consumer index can only mean an empty ring.

When fetch crediting is switched on, the block also issues one fetch credit for each posted descriptor. It caps the number of credits that are outstanding and takes credits back when a fetch completion reports how many descriptors it consumed. When crediting is off, only the producer index updates drive the fetch engine. After reset, the block emits one initial consumer-index arming write. This puts the completion side into a state where its triggers take effect. Posting is held off until that write has gone out.

Top module: `rpcm_ring_producer`

## Requirements
- R1: The producer index only takes values 0 to RING_SIZE-2. Slot RING_SIZE-1 is never presented, and from RING_SIZE-2 the index wraps to 0.
- R2: A post is accepted (post_ready high) only when the next producer index would differ from the registered consumer index. With RING_SIZE 8 and consumer index 0, the highest reachable producer index is 6 and the ring then holds 6 descriptors.
- R3: ring_empty is high exactly when producer and consumer index are equal. ring_full is high exactly when the next producer index equals the consumer index.
- R4: A consumer index update carrying the reserved value RING_SIZE-1 is ignored and leaves full and empty unchanged.
- R5: An accepted post raises pidx_upd_valid for one cycle on the following clock cycle, with pidx_value already showing the advanced index.
- R6: With crd_en high, every accepted post produces exactly one crd_valid pulse. At most one pulse is issued per cycle, and the earliest one comes the cycle after the post's index update.
- R7: With crd_en low, no crd_valid pulse is issued, while posts still advance the producer index.
- R8: Outstanding credits never exceed CRD_MAX. Posts beyond the cap keep their credits pending until completions return room.
- R9: A fetch completion (fetch_done_valid) subtracts fetch_done_cnt from the outstanding credits. The count saturates at zero, and the pending credits then flow again.
- R10: After reset release, arm_valid pulses exactly once, in the first clock cycle. post_ready stays low up to and including that cycle.
- R11: During reset the producer index is 0, ring_empty is high, ring_full is low, and post_ready, pidx_upd_valid, crd_valid and arm_valid are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crd_en | input | 1 | Fetch crediting enable |
| post_valid | input | 1 | Request to post one descriptor |
| post_ready | output | 1 | Post is accepted this cycle |
| cidx_valid | input | 1 | Consumer index update strobe |
| cidx_value | input | IDX_W | New consumer index |
| fetch_done_valid | input | 1 | Fetch completion strobe |
| fetch_done_cnt | input | CRD_W | Descriptors consumed by the completion |
| pidx_upd_valid | output | 1 | One-cycle producer index update pulse |
| pidx_value | output | IDX_W | Current producer index |
| crd_valid | output | 1 | One fetch credit issued this cycle |
| ring_full | output | 1 | No further post possible |
| ring_empty | output | 1 | Producer equals consumer index |
| arm_valid | output | 1 | Initial consumer-index arming write |

## Verification
If the wrap point were wrong, the bench would see a producer index of RING_SIZE-1 or a missing wrap on the very next post. If occupancy were tracked wrongly, ring_full or post_ready would show the error on the same cycle, once the ring nears capacity. A corrupted credit count appears within a few cycles, either as too many crd_valid pulses past the cap or as pending credits that never drain after a completion. A broken arming sequence is visible in the first two cycles after reset.

// File: rtl/rpcm_pkg.sv
package rpcm_pkg;
    // Arming sequence after reset: idle in reset, one send cycle, then done.
    typedef enum logic [1:0] {
        ARM_IDLE = 2'd0,
        ARM_SEND = 2'd1,
        ARM_DONE = 2'd2
    } arm_state_e;
endpackage

// File: rtl/rpcm_ring_ptr.sv
module rpcm_ring_ptr #(
    parameter int RING_SIZE = 8,
    localparam int IDX_W = $clog2(RING_SIZE)
) (
    input  logic [IDX_W-1:0] pidx,
    input  logic [IDX_W-1:0] cidx,
    output logic [IDX_W-1:0] pidx_next,
    output logic             full,
    output logic             empty
);
    // Highest slot a producer index may use; the slot above holds status.
    localparam logic [IDX_W-1:0] LAST_USE = IDX_W'(RING_SIZE - 2);

    always_comb begin
        pidx_next = (pidx == LAST_USE) ? '0 : pidx + 1'b1;
        full      = (pidx_next == cidx);
        empty     = (pidx == cidx);
    end
endmodule

// File: rtl/rpcm_credit_ctrl.sv
module rpcm_credit_ctrl #(
    parameter int CRD_MAX = 512,
    localparam int CRD_W = $clog2(CRD_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crd_en,
    input  logic             post_fire,
    input  logic             done_valid,
    input  logic [CRD_W-1:0] done_cnt,
    output logic             crd_valid,
    output logic             pend_sat,
    output logic [CRD_W-1:0] outst
);
    localparam logic [CRD_W-1:0] CAP = CRD_W'(CRD_MAX);

    typedef struct packed {
        logic [CRD_W-1:0] pend;
        logic [CRD_W-1:0] outst;
        logic             pulse;
    } crd_st_t;

    crd_st_t st_d, st_q;

    logic             issue;
    logic [CRD_W:0]   sum;
    logic [CRD_W:0]   ret;

    always_comb begin
        st_d  = st_q;
        issue = crd_en && (st_q.pend != '0) && (st_q.outst < CAP);
        sum   = {1'b0, st_q.outst} + {{CRD_W{1'b0}}, issue};
        ret   = done_valid ? {1'b0, done_cnt} : '0;
        st_d.outst = (ret > sum) ? '0 : CRD_W'(sum - ret);
        st_d.pend  = st_q.pend + CRD_W'(post_fire && crd_en) - CRD_W'(issue);
        st_d.pulse = issue;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign crd_valid = st_q.pulse;
    assign pend_sat  = (st_q.pend == '1);
    assign outst     = st_q.outst;
endmodule

// File: rtl/rpcm_ring_producer.sv
module rpcm_ring_producer
    import rpcm_pkg::*;
#(
    parameter int RING_SIZE = 8,
    parameter int CRD_MAX   = 512,
    localparam int IDX_W = $clog2(RING_SIZE),
    localparam int CRD_W = $clog2(CRD_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             crd_en,
    input  logic             post_valid,
    output logic             post_ready,
    input  logic             cidx_valid,
    input  logic [IDX_W-1:0] cidx_value,
    input  logic             fetch_done_valid,
    input  logic [CRD_W-1:0] fetch_done_cnt,
    output logic             pidx_upd_valid,
    output logic [IDX_W-1:0] pidx_value,
    output logic             crd_valid,
    output logic             ring_full,
    output logic             ring_empty,
    output logic             arm_valid
);
    localparam logic [IDX_W-1:0] LAST_USE = IDX_W'(RING_SIZE - 2);

    typedef struct packed {
        logic [IDX_W-1:0] pidx;
        logic [IDX_W-1:0] cidx;
        arm_state_e       arm;
        logic             upd;
    } prod_st_t;

    prod_st_t st_d, st_q;

    logic [IDX_W-1:0] pidx_next;
    logic [IDX_W-1:0] cidx_cur;
    logic             full_w;
    logic             empty_w;
    logic             pend_sat;
    logic             post_fire;
    logic [CRD_W-1:0] crd_outst;

    assign cidx_cur = st_q.cidx;

    rpcm_ring_ptr #(.RING_SIZE(RING_SIZE)) u_ptr (
        .pidx      (st_q.pidx),
        .cidx      (cidx_cur),
        .pidx_next (pidx_next),
        .full      (full_w),
        .empty     (empty_w)
    );

    assign post_ready = (st_q.arm == ARM_DONE) && !full_w && !pend_sat;
    assign post_fire  = post_valid && post_ready;

    always_comb begin
        st_d     = st_q;
        st_d.upd = post_fire;
        if (post_fire) begin
            st_d.pidx = pidx_next;
        end
        // Reserved status slot is never a legal consumer position.
        if (cidx_valid && (cidx_value <= LAST_USE)) begin
            st_d.cidx = cidx_value;
        end
        case (st_q.arm)
            ARM_IDLE: st_d.arm = ARM_SEND;
            ARM_SEND: st_d.arm = ARM_DONE;
            default:  st_d.arm = ARM_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pidx <= '0;
            st_q.cidx <= '0;
            st_q.arm  <= ARM_IDLE;
            st_q.upd  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    rpcm_credit_ctrl #(.CRD_MAX(CRD_MAX)) u_crd (
        .clk        (clk),
        .rst_n      (rst_n),
        .crd_en     (crd_en),
        .post_fire  (post_fire),
        .done_valid (fetch_done_valid),
        .done_cnt   (fetch_done_cnt),
        .crd_valid  (crd_valid),
        .pend_sat   (pend_sat),
        .outst      (crd_outst)
    );

    assign pidx_upd_valid = st_q.upd;
    assign pidx_value     = st_q.pidx;
    assign ring_full      = full_w;
    assign ring_empty     = empty_w;
    assign arm_valid      = (st_q.arm == ARM_SEND);
endmodule

// File: rtl/rpcm_checker.sv
module rpcm_checker #(
    parameter int RING_SIZE = 8,
    parameter int CRD_MAX   = 512,
    localparam int IDX_W = $clog2(RING_SIZE),
    localparam int CRD_W = $clog2(CRD_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             crd_en,
    input logic             post_valid,
    input logic             post_ready,
    input logic             pidx_upd_valid,
    input logic [IDX_W-1:0] pidx_value,
    input logic [IDX_W-1:0] cidx_q,
    input logic             crd_valid,
    input logic [CRD_W-1:0] outstanding,
    input logic             arm_valid,
    input logic             ring_full
);
    localparam logic [IDX_W-1:0] RSV = IDX_W'(RING_SIZE - 1);
    localparam logic [IDX_W-1:0] TOP = IDX_W'(RING_SIZE - 2);

    assert_pidx_not_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pidx_value != RSV);

    assert_pidx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_ready) |=> pidx_upd_valid &&
        (pidx_value == (($past(pidx_value) == TOP) ? '0 : $past(pidx_value) + 1'b1)));

    assert_no_catch_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (post_valid && post_ready) |=> pidx_value != $past(cidx_q));

    assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ring_full |-> !post_ready);

    assert_credit_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding <= CRD_W'(CRD_MAX));

    assert_no_credit_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !crd_en |=> !crd_valid);

    assert_arm_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid |=> !arm_valid);

    assert_arm_before_post_R10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_valid |-> !post_ready);
endmodule

bind rpcm_ring_producer rpcm_checker #(.RING_SIZE(RING_SIZE), .CRD_MAX(CRD_MAX)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .crd_en         (crd_en),
    .post_valid     (post_valid),
    .post_ready     (post_ready),
    .pidx_upd_valid (pidx_upd_valid),
    .pidx_value     (pidx_value),
    .cidx_q         (cidx_cur),
    .crd_valid      (crd_valid),
    .outstanding    (crd_outst),
    .arm_valid      (arm_valid),
    .ring_full      (ring_full)
);

// File: tb/rpcm_ring_producer_test.sv
module rpcm_ring_producer_test;
    localparam int RS    = 8;
    localparam int CM    = 4;
    localparam int IDX_W = $clog2(RS);
    localparam int CRD_W = $clog2(CM + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             crd_en = 1'b0;
    logic             post_valid = 1'b0;
    logic             post_ready;
    logic             cidx_valid = 1'b0;
    logic [IDX_W-1:0] cidx_value = '0;
    logic             fetch_done_valid = 1'b0;
    logic [CRD_W-1:0] fetch_done_cnt = '0;
    logic             pidx_upd_valid;
    logic [IDX_W-1:0] pidx_value;
    logic             crd_valid;
    logic             ring_full;
    logic             ring_empty;
    logic             arm_valid;

    int checks = 0;
    int fails  = 0;
    int crd_seen = 0;
    int arm_seen = 0;
    bit finished = 1'b0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    rpcm_ring_producer #(.RING_SIZE(RS), .CRD_MAX(CM)) uut (
        .clk(clk), .rst_n(rst_n), .crd_en(crd_en),
        .post_valid(post_valid), .post_ready(post_ready),
        .cidx_valid(cidx_valid), .cidx_value(cidx_value),
        .fetch_done_valid(fetch_done_valid), .fetch_done_cnt(fetch_done_cnt),
        .pidx_upd_valid(pidx_upd_valid), .pidx_value(pidx_value),
        .crd_valid(crd_valid), .ring_full(ring_full),
        .ring_empty(ring_empty), .arm_valid(arm_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: compares index updates with the scoreboard and counts pulses.
    always @(negedge clk) begin
        if (rst_n) begin
            if (crd_valid) crd_seen++;
            if (arm_valid) arm_seen++;
            if (pidx_upd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected update", int'(pidx_value), -1);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(pidx_value) == e, "R5/R1 pidx", int'(pidx_value), e);
                end
            end
        end
    end

    // Driver: one post attempt; pushes the expected index when accepted.
    task automatic post_one(input bit expect_ok, input int exp_idx, input string req);
        @(negedge clk);
        post_valid = 1'b1;
        check(post_ready == expect_ok, req, int'(post_ready), int'(expect_ok));
        if (post_ready) exp_q.push_back(exp_idx);
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    task automatic set_cidx(input int v);
        @(negedge clk);
        cidx_valid = 1'b1;
        cidx_value = IDX_W'(v);
        @(negedge clk);
        cidx_valid = 1'b0;
    endtask

    task automatic fetch_done(input int n);
        @(negedge clk);
        fetch_done_valid = 1'b1;
        fetch_done_cnt   = CRD_W'(n);
        @(negedge clk);
        fetch_done_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11 reset state
        check(pidx_value == 0, "R11 pidx", int'(pidx_value), 0);
        check(ring_empty && !ring_full, "R11 empty/full", int'({ring_empty, ring_full}), 2);
        check(!post_ready && !pidx_upd_valid && !crd_valid && !arm_valid,
              "R11 outputs low", int'({post_ready, pidx_upd_valid, crd_valid, arm_valid}), 0);
        rst_n  = 1'b1;
        crd_en = 1'b1;
        @(negedge clk);
        // R10 arm pulse in the first cycle, posting still blocked
        check(arm_valid == 1'b1, "R10 arm pulse", int'(arm_valid), 1);
        check(post_ready == 1'b0, "R10 ready during arm", int'(post_ready), 0);
        @(negedge clk);
        check(arm_valid == 1'b0 && post_ready == 1'b1, "R10 after arm",
              int'({arm_valid, post_ready}), 1);

        // R2: fill ring, highest index 6 with cidx 0
        for (int i = 1; i <= 6; i++) post_one(1'b1, i, "R2 accept");
        idle(2);
        check(ring_full == 1'b1, "R3 full", int'(ring_full), 1);
        post_one(1'b0, 0, "R2 stall when full");
        idle(8);
        // R8: only CM credits out
        check(crd_seen == 4, "R8 credit cap", crd_seen, 4);
        fetch_done(2);
        idle(6);
        check(crd_seen == 6, "R9/R6 credits after return", crd_seen, 6);
        // R9 saturating return
        fetch_done(7);
        idle(2);

        // R4 reserved consumer index ignored
        set_cidx(7);
        idle(1);
        check(ring_full == 1'b1 && ring_empty == 1'b0, "R4 reserved cidx ignored",
              int'({ring_full, ring_empty}), 2);

        // R1 wrap 6 -> 0
        set_cidx(3);
        idle(1);
        check(ring_full == 1'b0, "R3 not full", int'(ring_full), 0);
        post_one(1'b1, 0, "R1 wrap accept");
        post_one(1'b1, 1, "R1 accept");
        post_one(1'b1, 2, "R1 accept");
        idle(1);
        post_one(1'b0, 0, "R2 stall before cidx");
        idle(6);
        check(crd_seen == 9, "R9 saturation then R6 credits", crd_seen, 9);

        // R7 crediting off
        crd_en = 1'b0;
        set_cidx(2);
        idle(1);
        check(ring_empty == 1'b1, "R3 empty", int'(ring_empty), 1);
        post_one(1'b1, 3, "R7 accept");
        post_one(1'b1, 4, "R7 accept");
        idle(6);
        check(crd_seen == 9, "R7 no credits", crd_seen, 9);
        check(exp_q.size() == 0, "R5 all updates seen", exp_q.size(), 0);
        check(arm_seen == 1, "R10 single arm", arm_seen, 1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule